// File: doc/BRIEF.md
# Packed Increment Vector Interpreter

This block walks a stream of 8-bit beam commands that are packed two to a 16-bit word. With each command it updates a pair of 16-bit beam position registers and reports one step. It is entered from processor mode with the entering instruction word and that word's address. The first command it runs is the low byte of that instruction word. Every later word is read through a simple request/valid memory port and is run high byte first, then low byte.

A byte with bit 7 clear is a control byte. It can add a coarse step of 16 to X or Y and can clear the four low bits of either axis, always with the beam off. If bit 6 is also set, it is an escape: the block goes idle and reports the address one word past the word that held the escape. Bit 5 of an escape also raises a return request. A byte with bit 7 set is a draw byte. It moves X and Y by signed 2-bit magnitudes multiplied by a scale register, and bit 6 gives the beam state.

The scale is loaded from outside with a 2-bit value and a modifier bit. Positions wrap modulo 2^16, and positions and scale persist from one entry to the next.

Top module: `incr_vector_interp`

## Requirements
- R1: After reset, x_pos and y_pos are 0, step_valid, exit_valid, ret_req, busy and mem_req are low, and the scale is 1.
- R2: On start while idle, the first byte run is start_word[7:0]. start_word[15:8] is never run. The next word is read from start_pc+1 and later words from consecutive addresses, each run bits 15:8 first, then bits 7:0.
- R3: A control byte (bit7=0) adds 16 to X if bit4 is set, clears X[3:0] if bit3 is set, adds 16 to Y if bit1 is set, and clears Y[3:0] if bit0 is set. The add happens before the clear. The step is reported with beam_on=0.
- R4: A control byte with bit6=1 is an escape. Its moves still apply. The cycle after it, exit_valid pulses for one cycle with exit_pc equal to the address of the word holding the escape plus 1, and busy is low.
- R5: ret_req pulses together with exit_valid exactly when the escape byte has bit5 set.
- R6: A draw byte (bit7=1) reports beam_on equal to bit6. It moves X by bits[4:3] times the scale, negative when bit5=1. It moves Y by bits[1:0] times the scale, negative when bit2=1.
- R7: A scale load sets the scale to scale_c+4 when scale_mod=1 and to scale_c otherwise.
- R8: A scale load in the same cycle as a byte is run takes effect from the following byte on.
- R9: X and Y wrap modulo 2^16 in both directions.
- R10: While a word read is pending, mem_req stays high with a stable mem_addr until mem_valid, and no byte is run.
- R11: start is ignored while busy.
- R12: One byte is run per cycle when no read is pending, so the low byte of a fetched word is reported on the cycle after its high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Enter interpretation (taken only when idle) |
| start_word | input | 16 | Entering instruction word; its low byte is run first |
| start_pc | input | ADDR_W | Address of the entering instruction word |
| scale_load | input | 1 | Load the scale register |
| scale_c | input | 2 | Scale base value |
| scale_mod | input | 1 | Adds 4 to the loaded scale |
| mem_req | output | 1 | Word read request |
| mem_addr | output | ADDR_W | Word read address |
| mem_rdata | input | 16 | Read data, taken when mem_valid |
| mem_valid | input | 1 | Read data valid |
| x_pos | output | POS_W | Beam X position |
| y_pos | output | POS_W | Beam Y position |
| beam_on | output | 1 | Beam state of the last reported step |
| step_valid | output | 1 | A byte was run; positions and beam are new |
| exit_valid | output | 1 | One-cycle pulse after an escape |
| exit_pc | output | ADDR_W | Address at which processor mode resumes |
| ret_req | output | 1 | Return-from-subroutine request, with exit_valid |
| busy | output | 1 | Interpreter active |

## Verification
Two things can fall in the same cycle: a scale load and the running of a draw byte. The bench provokes this by asserting scale_load in the cycle right after start, when the entry byte is run. Its model expects that byte to use the old scale and every later byte to use the new one. A second overlap is start arriving while the block is busy. This is provoked in the middle of a session, and the bench judges it by the exit address and the count of reported steps, which must match the program that is actually running.

// File: rtl/ivi_pkg.sv
// Shared types and the byte decoder of the increment vector interpreter.
// Assumes 8-bit commands packed two per 16-bit word.
package ivi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FETCH = 2'd2
    } ivi_state_e;

    typedef struct packed {
        logic       is_draw;
        logic       escape;
        logic       ret;
        logic       beam;
        logic       x_coarse;
        logic       x_clr;
        logic       y_coarse;
        logic       y_clr;
        logic       x_neg;
        logic [1:0] x_mag;
        logic       y_neg;
        logic [1:0] y_mag;
    } ivi_cmd_t;

    // Splits one command byte into its control or draw fields.
    function automatic ivi_cmd_t decode_byte(input logic [7:0] b);
        ivi_cmd_t c;
        c = '0;
        c.is_draw = b[7];
        if (b[7]) begin
            c.beam  = b[6];
            c.x_neg = b[5];
            c.x_mag = b[4:3];
            c.y_neg = b[2];
            c.y_mag = b[1:0];
        end else begin
            c.escape   = b[6];
            c.ret      = b[6] & b[5];
            c.x_coarse = b[4];
            c.x_clr    = b[3];
            c.y_coarse = b[1];
            c.y_clr    = b[0];
        end
        return c;
    endfunction

endpackage

// File: rtl/ivi_step_calc.sv
// Turns the signed 2-bit magnitudes of a draw byte into position deltas.
// Assumes the magnitudes are zero for control bytes, giving zero deltas.
module ivi_step_calc #(
    parameter int POS_W   = 16,
    parameter int SCALE_W = 3
) (
    input  logic [1:0]         x_mag,
    input  logic               x_neg,
    input  logic [1:0]         y_mag,
    input  logic               y_neg,
    input  logic [SCALE_W-1:0] scale,
    output logic [POS_W-1:0]   dx,
    output logic [POS_W-1:0]   dy
);
    localparam int PROD_W = 2 + SCALE_W;

    logic [1:0]       mag [2];
    logic             neg [2];
    logic [POS_W-1:0] del [2];

    assign mag[0] = x_mag;
    assign mag[1] = y_mag;
    assign neg[0] = x_neg;
    assign neg[1] = y_neg;

    for (genvar a = 0; a < 2; a++) begin : g_axis
        logic [PROD_W-1:0] prod;
        logic [POS_W-1:0]  ext;
        // Magnitude times scale, then two's-complement negation when signed.
        always_comb begin
            prod     = PROD_W'(mag[a]) * PROD_W'(scale);
            ext      = POS_W'(prod);
            del[a]   = neg[a] ? (~ext + POS_W'(1)) : ext;
        end
    end

    assign dx = del[0];
    assign dy = del[1];
endmodule

// File: rtl/ivi_axis.sv
// One beam position register: coarse add, low-bit clear, then delta add.
// Assumes at most one of (coarse/clear) and (delta) is nonzero per step.
module ivi_axis #(
    parameter int POS_W    = 16,
    parameter int LOW_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             coarse,
    input  logic             clr_low,
    input  logic [POS_W-1:0] delta,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] COARSE_STEP = POS_W'(1) << LOW_BITS;
    localparam logic [POS_W-1:0] LOW_MASK    = COARSE_STEP - POS_W'(1);

    logic [POS_W-1:0] stepped;
    logic [POS_W-1:0] cleared;

    // Next position: coarse step, then truncation, then relative move.
    always_comb begin
        stepped = pos + (coarse ? COARSE_STEP : '0);
        cleared = clr_low ? (stepped & ~LOW_MASK) : stepped;
    end

    // Position register, wrapping modulo 2^POS_W.
    always_ff @(posedge clk) begin
        if (!rst_n)   pos <= '0;
        else if (en)  pos <= cleared + delta;
    end

    // R3
    low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr_low && delta == '0) |=> (pos[LOW_BITS-1:0] == '0));
endmodule

// File: rtl/ivi_sequencer.sv
// Word sequencer: takes the entry word, selects bytes in order, fetches
// following words and handles escapes. Assumes mem_rdata is valid with mem_valid.
module ivi_sequencer
    import ivi_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       start_word,
    input  logic [ADDR_W-1:0] start_pc,
    input  logic              esc,
    input  logic              ret_bit,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_valid,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              fire,
    output logic [7:0]        cur_byte,
    output logic              busy,
    output logic              exit_q,
    output logic              ret_q,
    output logic [ADDR_W-1:0] exit_pc
);
    ivi_state_e        state;
    logic [15:0]       word_q;
    logic              half_lo;
    logic [ADDR_W-1:0] pc_q;

    // Byte selection and handshake outputs.
    always_comb begin
        fire     = (state == ST_RUN);
        cur_byte = half_lo ? word_q[7:0] : word_q[15:8];
        mem_req  = (state == ST_FETCH);
        mem_addr = pc_q;
        busy     = (state != ST_IDLE);
    end

    // State, current word, half pointer, word address and exit reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            word_q  <= '0;
            half_lo <= 1'b0;
            pc_q    <= '0;
            exit_q  <= 1'b0;
            ret_q   <= 1'b0;
            exit_pc <= '0;
        end else begin
            exit_q <= 1'b0;
            ret_q  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        word_q  <= start_word;
                        half_lo <= 1'b1;
                        pc_q    <= start_pc;
                        state   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (esc) begin
                        state   <= ST_IDLE;
                        exit_q  <= 1'b1;
                        ret_q   <= ret_bit;
                        exit_pc <= pc_q + ADDR_W'(1);
                    end else if (half_lo) begin
                        pc_q  <= pc_q + ADDR_W'(1);
                        state <= ST_FETCH;
                    end else begin
                        half_lo <= 1'b1;
                    end
                end
                ST_FETCH: begin
                    if (mem_valid) begin
                        word_q  <= mem_rdata;
                        half_lo <= 1'b0;
                        state   <= ST_RUN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R4
    exit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_q |-> !busy);

    // R12
    byte_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !half_lo && !esc) |=> fire);
endmodule

// File: rtl/incr_vector_interp.sv
// Packed increment vector interpreter top: scale register, byte decode,
// step computation and the two position axes. Assumes one response per request.
module incr_vector_interp
    import ivi_pkg::*;
#(
    parameter int POS_W    = 16,
    parameter int ADDR_W   = 16,
    parameter int SCALE_W  = 3,
    parameter int LOW_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       start_word,
    input  logic [ADDR_W-1:0] start_pc,
    input  logic              scale_load,
    input  logic [1:0]        scale_c,
    input  logic              scale_mod,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_valid,
    output logic [POS_W-1:0]  x_pos,
    output logic [POS_W-1:0]  y_pos,
    output logic              beam_on,
    output logic              step_valid,
    output logic              exit_valid,
    output logic [ADDR_W-1:0] exit_pc,
    output logic              ret_req,
    output logic              busy
);
    localparam logic [SCALE_W-1:0] SCALE_RESET = SCALE_W'(1);

    logic [SCALE_W-1:0] scale_q;
    logic               fire;
    logic [7:0]         cur_byte;
    ivi_cmd_t           cmd;
    logic [POS_W-1:0]   dx, dy;

    logic             ax_coarse [2];
    logic             ax_clr    [2];
    logic [POS_W-1:0] ax_delta  [2];
    logic [POS_W-1:0] ax_pos    [2];

    // Decode the byte currently selected by the sequencer.
    always_comb cmd = decode_byte(cur_byte);

    // Scale register: base value plus 4 when the modifier is set.
    always_ff @(posedge clk) begin
        if (!rst_n)          scale_q <= SCALE_RESET;
        else if (scale_load) scale_q <= SCALE_W'({scale_mod, scale_c});
    end

    // Step strobe and beam state for each byte run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_valid <= 1'b0;
            beam_on    <= 1'b0;
        end else begin
            step_valid <= fire;
            if (fire) beam_on <= cmd.is_draw & cmd.beam;
        end
    end

    ivi_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_word (start_word),
        .start_pc   (start_pc),
        .esc        (cmd.escape),
        .ret_bit    (cmd.ret),
        .mem_rdata  (mem_rdata),
        .mem_valid  (mem_valid),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .fire       (fire),
        .cur_byte   (cur_byte),
        .busy       (busy),
        .exit_q     (exit_valid),
        .ret_q      (ret_req),
        .exit_pc    (exit_pc)
    );

    ivi_step_calc #(.POS_W(POS_W), .SCALE_W(SCALE_W)) u_calc (
        .x_mag (cmd.x_mag),
        .x_neg (cmd.x_neg),
        .y_mag (cmd.y_mag),
        .y_neg (cmd.y_neg),
        .scale (scale_q),
        .dx    (dx),
        .dy    (dy)
    );

    assign ax_coarse[0] = cmd.x_coarse;
    assign ax_coarse[1] = cmd.y_coarse;
    assign ax_clr[0]    = cmd.x_clr;
    assign ax_clr[1]    = cmd.y_clr;
    assign ax_delta[0]  = dx;
    assign ax_delta[1]  = dy;

    for (genvar a = 0; a < 2; a++) begin : g_ax
        ivi_axis #(.POS_W(POS_W), .LOW_BITS(LOW_BITS)) u_axis (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (fire),
            .coarse  (ax_coarse[a]),
            .clr_low (ax_clr[a]),
            .delta   (ax_delta[a]),
            .pos     (ax_pos[a])
        );
    end

    assign x_pos = ax_pos[0];
    assign y_pos = ax_pos[1];

    // R5
    ret_with_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_req |-> exit_valid);

    // R3
    control_beam_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !cmd.is_draw) |=> !beam_on);
endmodule

// File: tb/sim_incr_vector_interp.sv
module sim_incr_vector_interp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_word = '0;
    logic [15:0] start_pc = '0;
    logic        scale_load = 1'b0;
    logic [1:0]  scale_c = '0;
    logic        scale_mod = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        mem_valid = 1'b0;
    logic [15:0] x_pos, y_pos, exit_pc;
    logic        beam_on, step_valid, exit_valid, ret_req, busy;

    always #10 clk = ~clk;

    incr_vector_interp u0 (.*);

    int checks = 0, failures = 0, cycle = 0;
    logic [15:0] mem_arr [0:255];
    logic [7:0]  prog [0:63];
    int          nprog = 0;
    int          step_idx = 0, last_step_cycle = 0, fetch_k = 0;
    int          lat_cnt = 0, lat_tgt = 0, sc_switch_idx = 0;
    logic [3:0]  sc_now = 4'd1, sc_next = 4'd1;
    logic [15:0] mx = '0, my = '0, cur_spc = '0, exp_exit = '0;
    logic        exp_ret = 1'b0, sess_done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] rand_plain();
        logic [7:0] b = 8'($urandom);
        if (!b[7] && b[6]) b[6] = 1'b0;
        return b;
    endfunction

    // Bench memory: random latency, data on mem_valid; monitors at negedge.
    always @(negedge clk) begin
        cycle++;
        if (cycle > 150000) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycle, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
        if (mem_req) begin
            if (lat_cnt >= lat_tgt) begin
                if (!mem_valid) begin
                    // R10 and R2: consecutive word addresses after start_pc
                    chk(mem_addr == cur_spc + 16'(fetch_k + 1), "R2 fetch address", mem_addr, cur_spc + 16'(fetch_k + 1));
                    fetch_k++;
                end
                mem_valid = 1'b1;
                mem_rdata = mem_arr[mem_addr[7:0]];
            end else begin
                lat_cnt++;
                mem_valid = 1'b0;
            end
        end else begin
            mem_valid = 1'b0;
            lat_cnt   = 0;
            lat_tgt   = int'($urandom % 4);
        end
        if (step_valid) begin
            logic [7:0]  b;
            logic [3:0]  sc;
            logic [15:0] d;
            logic        eb;
            b  = prog[step_idx];
            sc = (step_idx >= sc_switch_idx) ? sc_next : sc_now;
            if (b[7]) begin
                d  = 16'(b[4:3]) * 16'(sc);
                mx = b[5] ? mx - d : mx + d;
                d  = 16'(b[1:0]) * 16'(sc);
                my = b[2] ? my - d : my + d;
                eb = b[6];
                // R6 and R9: draw move with wrap
                chk(x_pos == mx && y_pos == my && beam_on == eb, "R6 draw step",
                    {x_pos, y_pos}, {mx, my});
            end else begin
                if (b[4]) mx = mx + 16'd16;
                if (b[3]) mx = mx & 16'hFFF0;
                if (b[1]) my = my + 16'd16;
                if (b[0]) my = my & 16'hFFF0;
                // R3: control move, beam off
                chk(x_pos == mx && y_pos == my && !beam_on, "R3 control step",
                    {x_pos, y_pos}, {mx, my});
            end
            if (step_idx >= 2 && step_idx % 2 == 0)
                // R12: low byte right after high byte
                chk(cycle == last_step_cycle + 1, "R12 byte rate", cycle, last_step_cycle + 1);
            last_step_cycle = cycle;
            step_idx++;
        end
        if (exit_valid) begin
            // R4 and R5: exit address and return request
            chk(exit_pc == exp_exit && !busy, "R4 exit", exit_pc, exp_exit);
            chk(ret_req == exp_ret, "R5 return request", ret_req, exp_ret);
            sess_done = 1'b1;
        end
    end

    // Place prog[0..nprog-1] in memory behind an entry at spc and run it.
    task automatic run_prog(input logic [15:0] spc, input bit conc_scale,
                            input logic [1:0] cc, input bit cm, input bit poke);
        int last = nprog - 1;
        for (int i = 1; i < nprog; i++) begin
            int w = (i - 1) / 2 + 1;
            if ((i - 1) % 2 == 0) mem_arr[8'(spc + 16'(w))] = {prog[i], 8'($urandom)};
            else mem_arr[8'(spc + 16'(w))][7:0] = prog[i];
        end
        exp_exit  = spc + 16'(last == 0 ? 0 : (last - 1) / 2 + 1) + 16'd1;
        exp_ret   = prog[last][5];
        cur_spc   = spc;
        fetch_k   = 0;
        step_idx  = 0;
        sess_done = 1'b0;
        sc_switch_idx = 0;
        sc_now    = sc_next;
        @(negedge clk);
        start = 1'b1; start_pc = spc; start_word = {8'h40, prog[0]};
        @(negedge clk);
        start = 1'b0;
        if (conc_scale) begin
            sc_switch_idx = 1;
            sc_next = cm ? 4'(cc) + 4'd4 : 4'(cc);
            scale_load = 1'b1; scale_c = cc; scale_mod = cm;
            @(negedge clk);
            scale_load = 1'b0;
        end
        if (poke) begin
            repeat (2) @(negedge clk);
            if (busy) begin
                start = 1'b1; start_word = 16'h4040; start_pc = 16'd250;
                @(negedge clk);
                start = 1'b0;
            end
        end
        while (!sess_done) @(negedge clk);
        sc_now = sc_next;
        // R11 and R2: every byte of the program ran, no other
        chk(step_idx == nprog, "R11 step count", step_idx, nprog);
    endtask

    task automatic load_scale(input logic [1:0] cc, input bit cm);
        @(negedge clk);
        scale_load = 1'b1; scale_c = cc; scale_mod = cm;
        @(negedge clk);
        scale_load = 1'b0;
        sc_next = cm ? 4'(cc) + 4'd4 : 4'(cc);
        sc_now  = sc_next;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) mem_arr[i] = 16'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(x_pos == 0 && y_pos == 0, "R1 reset position", {x_pos, y_pos}, 0);
        chk(!busy && !mem_req && !step_valid && !exit_valid && !ret_req, "R1 reset controls",
            {busy, mem_req, step_valid, exit_valid, ret_req}, 0);

        // R1: reset scale 1; R2: entry low byte first, high byte 0x40 not run
        prog[0] = 8'hC9; prog[1] = 8'h40; nprog = 2;
        run_prog(16'd10, 0, 2'd0, 0, 0);
        chk(x_pos == 16'd1 && y_pos == 16'd1, "R1 reset scale", {x_pos, y_pos}, {16'd1, 16'd1});

        // R7 and R9: scale 3+4 and negative wrap
        load_scale(2'd3, 1'b1);
        prog[0] = 8'hBF; prog[1] = 8'h60; nprog = 2;
        run_prog(16'd20, 0, 2'd0, 0, 0);
        chk(x_pos == 16'hFFEC && y_pos == 16'hFFEC, "R9 wrap", {x_pos, y_pos}, 32'hFFECFFEC);
        chk(beam_on == 1'b0, "R7 scale c+4 beam", beam_on, 0);

        // R3 and R4: escape in the entry byte with coarse moves and clears
        prog[0] = 8'h7B; nprog = 1;
        run_prog(16'd30, 0, 2'd0, 0, 0);
        chk(x_pos == 16'hFFF0 && y_pos == 16'hFFF0, "R3 escape moves", {x_pos, y_pos}, 32'hFFF0FFF0);

        // R8: scale load in the same cycle as the entry draw byte
        prog[0] = 8'hDB; prog[1] = 8'hDB; prog[2] = 8'h40; nprog = 3;
        run_prog(16'd40, 1, 2'd2, 0, 0);
        chk(x_pos == 16'hFFF0 + 16'd21 + 16'd6, "R8 scale timing", x_pos, 16'hFFF0 + 16'd27);

        // R11: start while busy
        prog[0] = 8'h81; for (int i = 1; i < 9; i++) prog[i] = rand_plain();
        prog[9] = 8'h40; nprog = 10;
        run_prog(16'd50, 0, 2'd0, 0, 1);

        // Random sessions
        for (int s = 0; s < 40; s++) begin
            int n = 1 + int'($urandom % 30);
            if (s % 5 == 0) load_scale(2'($urandom), 1'($urandom));
            for (int i = 0; i < n; i++) prog[i] = rand_plain();
            prog[n] = {2'b01, 1'($urandom), 5'($urandom)};
            nprog = n + 1;
            run_prog(16'($urandom % 200), s % 7 == 3, 2'($urandom), 1'($urandom), s % 9 == 4);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule